// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel clock period, given in picoseconds, into the programming word for a serially loaded frequency synthesizer. A start strobe captures the period. One shared 32-bit restoring divider then runs three passes in turn. The first pass gives the output frequency in units of 0.01 MHz. The second and third passes give the rounded feedback count. Between the first and second passes, the frequency is range-checked and doubled into the oscillator window. Each doubling also doubles the post-divider.

The result is a 16-bit word together with the chosen post-divider ratio and an error flag. A one-cycle done pulse marks the result. The word packs three fields: the feedback count offset by 257, an inverted post-divider code, and two stop bits that are always set. Loading the word into the synthesizer happens elsewhere.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset, `done` and `err` are low, and `word` and `post_div` are zero.
- R2: The frequency is f = 100000000 / period_ps, using integer division. When 1000 <= f <= 15938, the calculation ends with `err` low.
- R3: If f > 15938, the calculation ends with `err` high, and `word` and `post_div` are zero.
- R4: If f < 1000, the calculation ends with `err` high, and `word` and `post_div` are zero.
- R5: A period of zero is rejected at once. `done` and `err` are high in the cycle right after the accepting edge, and no divide runs.
- R6: While f < 8000, f is doubled and the post-divider ratio is doubled, starting from 1. `post_div` reports the ratio as 1, 2, 4 or 8.
- R7: N = ((46 * fn * 1000) / 1432 + 500) / 1000, using integer division, where fn is the doubled frequency. `word[8:0]` holds N - 257.
- R8: `word[10:9]` encodes the post-divider as 3 for a ratio of 1, 2 for 2, 1 for 4 and 0 for 8.
- R9: On success, `word[12:11]` is 2'b11 and `word[15:13]` is zero.
- R10: `done` is high for exactly one cycle. Counting the edge that accepts `start` as edge 1, `done` is high after edge 1 for a zero period, after edge 34 for a range error, and after edge 100 for a success.
- R11: A `start` (with any period) that arrives while a calculation is running is ignored. The result reflects the period accepted first.
- R12: `word`, `post_div` and `err` hold their values from one result until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; sampled only when idle |
| period_ps | input | 32 | Requested pixel clock period in ps |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Request was out of range or zero |
| word | output | 16 | Synthesizer programming word |
| post_div | output | 4 | Chosen post-divider ratio (1, 2, 4, 8) |

## Verification
Every result appears at a fixed distance from the edge that accepts `start`. That distance is 1 edge for a zero period, 34 edges once the first divide shows the frequency is out of range, and 100 edges after all three divider passes. The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done` shows. It then compares that count with the latency predicted for the stimulus before it checks `err`, `word` and `post_div`. Partway through a run, it also confirms that the previous word has not changed and that a mid-run start has no effect.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FREQ  = 2'd1,
    ST_SCALE = 2'd2,
    ST_ROUND = 2'd3
  } pcw_state_e;
endpackage

// File: rtl/pcw_serial_div.sv
module pcw_serial_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic [W:0]    shl, dif;
  logic          ge;

  always_comb begin
    shl   = {rem_q, quo_q[W-1]};
    dif   = shl - {1'b0, den_q};
    ge    = (shl >= {1'b0, den_q});
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (load) begin
      rem_d = '0;
      quo_d = dividend;
      den_d = divisor;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      rem_d = ge ? dif[W-1:0] : shl[W-1:0];
      quo_d = {quo_q[W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign quot = quo_q;
  assign fin  = fin_q;
endmodule

// File: rtl/pcw_normalize.sv
module pcw_normalize #(
  parameter int W      = 32,
  parameter int VCO_LO = 8000,
  parameter int MAX_SH = 3,
  localparam int SHW   = $clog2(MAX_SH + 1)
) (
  input  logic [W-1:0]   f_in,
  output logic [W-1:0]   f_out,
  output logic [SHW-1:0] shift
);
  localparam logic [W-1:0] K_LO = W'(VCO_LO);

  always_comb begin
    f_out = f_in;
    shift = '0;
    for (int k = 0; k < MAX_SH; k++) begin
      if (f_out < K_LO) begin
        f_out = f_out << 1;
        shift = shift + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcw_encode.sv
module pcw_encode #(
  parameter int W         = 32,
  parameter int WW        = 16,
  parameter int MAX_SH    = 3,
  parameter int FB_OFS    = 257,
  parameter int CNT_W     = 9,
  parameter int STOP_BITS = 'h1800,
  localparam int SHW      = $clog2(MAX_SH + 1)
) (
  input  logic [W-1:0]   fb_count,
  input  logic [SHW-1:0] shift,
  output logic [WW-1:0]  word
);
  localparam logic [W-1:0] K_OFS  = W'(FB_OFS);
  localparam logic [W-1:0] K_MASK = W'((1 << CNT_W) - 1);
  localparam logic [W-1:0] K_STOP = W'(STOP_BITS);
  localparam logic [W-1:0] K_MSH  = W'(MAX_SH);

  logic [W-1:0] field;

  always_comb begin
    field = (K_MSH - W'(shift)) << CNT_W;
    word  = WW'(K_STOP | field | ((fb_count - K_OFS) & K_MASK));
  end
endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc
  import pcw_pkg::*;
#(
  parameter int PW       = 32,
  parameter int WW       = 16,
  parameter int MAX_SH   = 3,
  parameter int FREQ_NUM = 100000000,
  parameter int F_MAX    = 15938,
  parameter int F_MIN    = 1000,
  parameter int VCO_LO   = 8000,
  parameter int FB_MUL   = 46000,
  parameter int FB_DIV   = 1432,
  parameter int RND_ADD  = 500,
  parameter int RND_DIV  = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW-1:0]   period_ps,
  output logic            done,
  output logic            err,
  output logic [WW-1:0]   word,
  output logic [MAX_SH:0] post_div
);
  localparam int SHW = $clog2(MAX_SH + 1);
  localparam logic [PW-1:0] K_FNUM = PW'(FREQ_NUM);
  localparam logic [PW-1:0] K_FMAX = PW'(F_MAX);
  localparam logic [PW-1:0] K_FMIN = PW'(F_MIN);
  localparam logic [PW-1:0] K_FBM  = PW'(FB_MUL);
  localparam logic [PW-1:0] K_FBD  = PW'(FB_DIV);
  localparam logic [PW-1:0] K_RADD = PW'(RND_ADD);
  localparam logic [PW-1:0] K_RDIV = PW'(RND_DIV);

  pcw_state_e        state_q, state_d;
  logic [SHW-1:0]    sh_q, sh_d;
  logic              done_q, done_d, err_q, err_d;
  logic [WW-1:0]     word_q, word_d;
  logic [MAX_SH:0]   post_q, post_d;
  logic              div_load, div_fin;
  logic [PW-1:0]     div_num, div_den, div_quot;
  logic [PW-1:0]     norm_f;
  logic [SHW-1:0]    norm_sh;
  logic [WW-1:0]     enc_word;
  logic              out_rng;
  logic              idle;

  pcw_serial_div #(.W(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(div_num),
    .divisor(div_den), .quot(div_quot), .fin(div_fin)
  );

  pcw_normalize #(.W(PW), .VCO_LO(VCO_LO), .MAX_SH(MAX_SH)) u_norm (
    .f_in(div_quot), .f_out(norm_f), .shift(norm_sh)
  );

  pcw_encode #(.W(PW), .WW(WW), .MAX_SH(MAX_SH)) u_enc (
    .fb_count(div_quot), .shift(sh_q), .word(enc_word)
  );

  assign idle    = (state_q == ST_IDLE);
  assign out_rng = (div_quot > K_FMAX) || (div_quot < K_FMIN);

  always_comb begin
    state_d  = state_q;
    sh_d     = sh_q;
    done_d   = 1'b0;
    err_d    = err_q;
    word_d   = word_q;
    post_d   = post_q;
    div_load = 1'b0;
    div_num  = K_FNUM;
    div_den  = period_ps;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (period_ps == '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            word_d = '0;
            post_d = '0;
          end else begin
            div_load = 1'b1;
            state_d  = ST_FREQ;
          end
        end
      end
      ST_FREQ: begin
        if (div_fin) begin
          if (out_rng) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            word_d  = '0;
            post_d  = '0;
            state_d = ST_IDLE;
          end else begin
            div_load = 1'b1;
            div_num  = K_FBM * norm_f;
            div_den  = K_FBD;
            sh_d     = norm_sh;
            state_d  = ST_SCALE;
          end
        end
      end
      ST_SCALE: begin
        if (div_fin) begin
          div_load = 1'b1;
          div_num  = div_quot + K_RADD;
          div_den  = K_RDIV;
          state_d  = ST_ROUND;
        end
      end
      ST_ROUND: begin
        if (div_fin) begin
          done_d  = 1'b1;
          err_d   = 1'b0;
          word_d  = enc_word;
          post_d  = (MAX_SH+1)'(1) << sh_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
      post_q  <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
      err_q   <= err_d;
      word_q  <= word_d;
      post_q  <= post_d;
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign word     = word_q;
  assign post_div = post_q;
endmodule

// File: rtl/pcw_chk.sv
module pcw_chk #(
  parameter int PW     = 32,
  parameter int WW     = 16,
  parameter int MAX_SH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [PW-1:0]   period_ps,
  input logic            idle,
  input logic            done,
  input logic            err,
  input logic [WW-1:0]   word,
  input logic [MAX_SH:0] post_div
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R9
  stop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word[12:11] == 2'b11 && word[WW-1:13] == '0));

  // R6
  post_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($countones(post_div) == 1));

  // R5
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && period_ps == '0) |=> (done && err));

  // R12
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(word) && $stable(post_div) && $stable(err))));
endmodule

bind pclk_word_calc pcw_chk #(.PW(PW), .WW(WW), .MAX_SH(MAX_SH)) u_chk (.*);

// File: tb/tb_pclk_word_calc.sv
module tb_pclk_word_calc;
  logic        clk, rst_n, start;
  logic [31:0] period_ps;
  logic        done, err;
  logic [15:0] word;
  logic [3:0]  post_div;
  int checks = 0;
  int fails  = 0;

  pclk_word_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .done(done), .err(err), .word(word), .post_div(post_div)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] p, output bit e,
      output logic [15:0] w, output logic [3:0] pd, output int lat, output string etag);
    longint f, n;
    int sh;
    e = 0; w = 0; pd = 0; lat = 100; etag = "R2";
    if (p == 0) begin
      e = 1; lat = 1; etag = "R5";
      return;
    end
    f = 100000000 / longint'(p);
    if (f > 15938) begin e = 1; lat = 34; etag = "R3"; return; end
    if (f < 1000)  begin e = 1; lat = 34; etag = "R4"; return; end
    sh = 0;
    while (f < 8000) begin f = f * 2; sh++; end
    n  = ((46 * f * 1000) / 1432 + 500) / 1000;
    w  = 16'h1800 | 16'((3 - sh) << 9) | 16'(n - 257);
    pd = 4'(1 << sh);
  endfunction

  task automatic run(input logic [31:0] p, input bit inj, input logic [31:0] p2);
    bit e; logic [15:0] w; logic [3:0] pd; int lat; string etag;
    logic [15:0] old_w;
    int cnt;
    model(p, e, w, pd, lat, etag);
    old_w = word;
    @(negedge clk);
    start = 1'b1; period_ps = p;
    @(negedge clk);
    start = 1'b0; period_ps = $urandom;
    cnt = 1;
    while (!done && cnt < 300) begin
      if (cnt == 2) chk("R12", word == old_w, word, old_w);
      start = (inj && cnt == 5);
      if (inj && cnt == 5) period_ps = p2;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk("R10", cnt == lat, cnt, lat);
    chk(etag, err == e, err, e);
    if (!e) begin
      chk(inj ? "R11" : "R7", word[8:0] == w[8:0], word[8:0], w[8:0]);
      chk("R8", word[10:9] == w[10:9], word[10:9], w[10:9]);
      chk("R9", word[15:11] == w[15:11], word[15:11], w[15:11]);
      chk("R6", post_div == pd, post_div, pd);
    end else begin
      chk(etag, word == 16'h0 && post_div == 4'h0, {post_div, word}, 0);
    end
    @(negedge clk);
    chk("R10", done == 1'b0, done, 0);
  endtask

  initial begin
    #(200000 * 8);
    chk("watchdog", 1'b0, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; period_ps = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", done == 0 && err == 0, {done, err}, 0);
    chk("R1", word == 0 && post_div == 0, {post_div, word}, 0);
    // directed corners
    run(32'd0, 0, 0);              // R5
    run(32'd6273, 0, 0);           // R3 just above max
    run(32'd6274, 0, 0);           // R2 at max
    run(32'd100000, 0, 0);         // R4 edge: f = 1000, divide by 8
    run(32'd100001, 0, 0);         // R4 just below min
    run(32'd12500, 0, 0);          // R6 f = 8000, divide by 1
    run(32'd12501, 0, 0);          // R6 f = 7999, divide by 2
    run(32'd25001, 0, 0);          // R6 divide by 4
    run(32'd1, 0, 0);              // R3 huge frequency
    run(32'hFFFF_FFFF, 0, 0);      // R4 f = 0
    run(32'd40000, 1, 32'd0);      // R11 start during busy ignored
    run(32'd15000, 1, 32'd7000);   // R11
    for (int i = 0; i < 40; i++) begin
      run(32'd6000 + ($urandom % 32'd104000), (i % 7) == 3, $urandom % 32'd50000);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule